// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Priority Controller

This block arbitrates among seven interrupt request lines on behalf of an 8-bit CPU core. Each line has its own enable bit, and a master enable gates them all. Two priority bits per line, one from a high priority word and one from a low priority word, place the line on one of four levels. The block presents the winning request to the core with a vector address, a source index and its level. Every output is combinational from the inputs and a small in-service state.

The core acknowledges a request with a one-cycle `ack_i` pulse. The controller then records the granted level as in service. On the same cycle it pulses a flag-clear line for any source whose flag is cleared by hardware. A one-cycle `reti_i` pulse retires the most recently entered level. A new request is offered only when its level is above every level currently in service. A higher level therefore preempts a lower one, and the lower service continues after the return.

Source bit indices used on every per-source vector: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2, bit 6 capture/compare array. Bit 7 of `en_i` is the master enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The level of source x is {prio_hi_i[x], prio_lo_i[x]}, where 0 is lowest and 3 is highest. Among active requests, the highest level always wins, whatever its polling position.
- R2: While en_i[7] is 0, irq_o stays 0. While en_i[7] is 1, a source whose own en_i bit is 0 is never granted.
- R3: An active request is offered only if its level is strictly greater than the highest level in service. A request at a level equal to or below it keeps irq_o low.
- R4: A request whose level is above the level in service raises irq_o (preemption). After the matching reti_i, a lower pending request is offered again.
- R5: Within one level, the polling order is bit 0, 1, 2, 3, 6, 4, 5. The earliest active source in that order is offered.
- R6: With irq_o high, vec_o = 03h + 8 * src_o. This gives bit0 03h, bit1 0Bh, bit2 13h, bit3 1Bh, bit4 23h, bit5 2Bh and bit6 33h. With irq_o low, vec_o = 0.
- R7: An ack_i while irq_o is high marks lvl_o as in service. From the next cycle, irq_o stays low until a request above that level is active.
- R8: The timer 0 and timer 1 sources (bits 1, 3) get a clr_o pulse in the cycle they are acknowledged.
- R9: External sources (bits 0, 2) get a clr_o pulse on acknowledge only when edge_i[0] or edge_i[1], respectively, is 1. When that bit is 0 (level-triggered), no pulse is given.
- R10: Bits 4, 5 and 6 of clr_o never assert.
- R11: reti_i clears only the highest level in service. Lower levels stay in service.
- R12: After reset, no level is in service, and irq_o and clr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Request lines, one per source bit |
| en_i | input | 8 | Per-source enables [6:0], master enable [7] |
| prio_lo_i | input | 7 | Low priority bit per source |
| prio_hi_i | input | 7 | High priority bit per source |
| edge_i | input | 2 | Edge-triggered configuration of external 0 [0] and external 1 [1] |
| ack_i | input | 1 | Core accepts the offered request |
| reti_i | input | 1 | Core returns from the current service |
| irq_o | output | 1 | Request to the core |
| src_o | output | 3 | Offered source bit index |
| lvl_o | output | 2 | Offered level |
| vec_o | output | 8 | Offered vector address |
| clr_o | output | 7 | One-cycle hardware flag clear per source |

## Verification
A corrupted in-service mask shows at the ports within one cycle. Either a request at an already active level is offered again, or a preempting request is held off. A lost reti leaves a lower pending source blocked, while a double clear lets a same-level source through early. Each nesting step is followed by a check one cycle after the ack or reti edge, so a wrong mask update is caught on the next sample, before further stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 7;
  localparam int LVLS   = 4;
  localparam int LVL_W  = $clog2(LVLS);
  localparam int SRC_W  = $clog2(NSRC);
  localparam int VEC_W  = 8;
  localparam int IDX_X0 = 0;
  localparam int IDX_T0 = 1;
  localparam int IDX_X1 = 2;
  localparam int IDX_T1 = 3;

  // polling rank -> source bit index
  function automatic int poll_idx(input int rank);
    case (rank)
      4:       return 6;
      5:       return 4;
      6:       return 5;
      default: return rank;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] src);
    return VEC_W'(3 + 8 * int'(src));
  endfunction
endpackage

// File: rtl/irq_lvl_sel.sv
module irq_lvl_sel
  import irq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int L = LVLS
) (
  input  logic [N-1:0]            act_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  output logic                    any_o,
  output logic [LVL_W-1:0]        top_o
);
  logic [L-1:0] hit;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    logic [N-1:0] m;
    for (genvar s = 0; s < N; s++) begin : g_src
      assign m[s] = act_i[s] && (lvl_i[s] == LVL_W'(l));
    end
    assign hit[l] = |m;
  end

  always_comb begin
    top_o = '0;
    for (int l = 0; l < L; l++) begin
      if (hit[l]) top_o = LVL_W'(l);
    end
  end

  assign any_o = |hit;
endmodule

// File: rtl/irq_poll_pick.sv
module irq_poll_pick
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     cand_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o
);
  // scan from last rank down so the earliest rank wins
  always_comb begin
    src_o = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (cand_i[poll_idx(r)]) src_o = SRC_W'(poll_idx(r));
    end
  end

  assign valid_o = |cand_i;
endmodule

// File: rtl/irq_insvc.sv
module irq_insvc
  import irq_pkg::*;
#(
  parameter int L = LVLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [LVL_W-1:0] set_lvl_i,
  input  logic             pop_i,
  output logic             busy_o,
  output logic [LVL_W-1:0] top_o
);
  logic [L-1:0] mask_q, mask_d;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < L; l++) begin
      if (mask_q[l]) top_o = LVL_W'(l);
    end
  end

  assign busy_o = |mask_q;

  // retire first, then record the new grant
  always_comb begin
    mask_d = mask_q;
    if (pop_i && busy_o) mask_d[top_o] = 1'b0;
    if (set_i) mask_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0]      req_i,
  input  logic [NSRC:0]        en_i,
  input  logic [NSRC-1:0]      prio_lo_i,
  input  logic [NSRC-1:0]      prio_hi_i,
  input  logic [1:0]           edge_i,
  input  logic                 ack_i,
  input  logic                 reti_i,
  output logic                 irq_o,
  output logic [SRC_W-1:0]     src_o,
  output logic [LVL_W-1:0]     lvl_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [NSRC-1:0]      clr_o
);
  logic [NSRC-1:0]            act, cand;
  logic [NSRC-1:0][LVL_W-1:0] lvl;
  logic                       any_act, cand_vld, svc_busy, grant;
  logic [LVL_W-1:0]           top_lvl, svc_top;
  logic [SRC_W-1:0]           pick;

  assign act = req_i & en_i[NSRC-1:0] & {NSRC{en_i[NSRC]}};

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign lvl[s]  = {prio_hi_i[s], prio_lo_i[s]};
    assign cand[s] = act[s] && (lvl[s] == top_lvl);
  end

  irq_lvl_sel #(.N(NSRC), .L(LVLS)) u_lvl_sel (
    .act_i (act),
    .lvl_i (lvl),
    .any_o (any_act),
    .top_o (top_lvl)
  );

  irq_poll_pick #(.N(NSRC)) u_pick (
    .cand_i  (cand),
    .valid_o (cand_vld),
    .src_o   (pick)
  );

  irq_insvc #(.L(LVLS)) u_insvc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant),
    .set_lvl_i (top_lvl),
    .pop_i     (reti_i),
    .busy_o    (svc_busy),
    .top_o     (svc_top)
  );

  assign irq_o = any_act && cand_vld && (!svc_busy || (top_lvl > svc_top));
  assign grant = ack_i && irq_o;
  assign src_o = irq_o ? pick : '0;
  assign lvl_o = irq_o ? top_lvl : '0;
  assign vec_o = irq_o ? vec_of(pick) : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_clr
    if (s == IDX_T0 || s == IDX_T1) begin : g_timer
      assign clr_o[s] = grant && (pick == SRC_W'(s));
    end else if (s == IDX_X0) begin : g_ext0
      assign clr_o[s] = grant && (pick == SRC_W'(s)) && edge_i[0];
    end else if (s == IDX_X1) begin : g_ext1
      assign clr_o[s] = grant && (pick == SRC_W'(s)) && edge_i[1];
    end else begin : g_keep
      assign clr_o[s] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NSRC-1:0]      req_i,
  input logic [NSRC:0]        en_i,
  input logic [NSRC-1:0]      prio_lo_i,
  input logic [NSRC-1:0]      prio_hi_i,
  input logic                 ack_i,
  input logic                 reti_i,
  input logic                 irq_o,
  input logic [SRC_W-1:0]     src_o,
  input logic [LVL_W-1:0]     lvl_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [NSRC-1:0]      clr_o
);
  function automatic int max_active();
    int m = -1;
    for (int s = 0; s < NSRC; s++) begin
      if (req_i[s] && en_i[s] && en_i[NSRC] && int'({prio_hi_i[s], prio_lo_i[s]}) > m)
        m = int'({prio_hi_i[s], prio_lo_i[s]});
    end
    return m;
  endfunction

  assert_master_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[NSRC] |-> !irq_o);

  assert_src_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req_i[src_o] && en_i[src_o]));

  assert_top_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(lvl_o) == max_active()));

  assert_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o == VEC_W'(8'h03 + {src_o, 3'b000})));

  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (!irq_o || (lvl_o > $past(lvl_o))));

  assert_clr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

  assert_clr_on_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> (ack_i && irq_o && clr_o[src_o]));

  assert_no_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o[6:4] == 3'b000);
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .en_i      (en_i),
  .prio_lo_i (prio_lo_i),
  .prio_hi_i (prio_hi_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .irq_o     (irq_o),
  .src_o     (src_o),
  .lvl_o     (lvl_o),
  .vec_o     (vec_o),
  .clr_o     (clr_o)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic [6:0] req_i = 0, prio_lo_i = 0, prio_hi_i = 0;
  logic [7:0] en_i = 8'hFF;
  logic [1:0] edge_i = 0;
  logic       ack_i = 0, reti_i = 0;
  logic       irq_o;
  logic [2:0] src_o;
  logic [1:0] lvl_o;
  logic [7:0] vec_o;
  logic [6:0] clr_o;

  irq_prio_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic irq; logic [2:0] src; logic [1:0] lvl; logic [7:0] vec; logic [6:0] clr; string tag;
  } exp_t;

  exp_t q[$];
  event ev_sample;
  int   n_chk = 0, n_fail = 0;
  logic [3:0] m_mask = 0;
  bit   done = 0;

  // reference model from the requirements
  function automatic void model(output logic irq, output logic [2:0] src,
                                output logic [1:0] lvl, output logic [6:0] clr);
    int ord[7] = '{0, 1, 2, 3, 6, 4, 5};
    int best = -1, bs = 0, top = -1;
    for (int k = 0; k < 7; k++) begin
      int s = ord[k];
      if (req_i[s] && en_i[s] && en_i[7] && int'({prio_hi_i[s], prio_lo_i[s]}) > best) begin
        best = int'({prio_hi_i[s], prio_lo_i[s]}); bs = s;
      end
    end
    for (int l = 0; l < 4; l++) if (m_mask[l]) top = l;
    irq = rst_ni && (best > top);
    src = irq ? 3'(bs) : 3'd0;
    lvl = irq ? 2'(best) : 2'd0;
    clr = 0;
    if (irq && ack_i && (bs == 1 || bs == 3 || (bs == 0 && edge_i[0]) || (bs == 2 && edge_i[1])))
      clr[bs] = 1'b1;
  endfunction

  task automatic chk(input string tag);
    exp_t e;
    #1;
    model(e.irq, e.src, e.lvl, e.clr);
    e.vec = e.irq ? 8'(3 + 8 * int'(e.src)) : 8'h00;
    e.tag = tag;
    q.push_back(e);
    ->ev_sample;
    @(posedge clk_i);
    if (rst_ni && reti_i) begin
      for (int l = 3; l >= 0; l--) if (m_mask[l]) begin m_mask[l] = 0; break; end
    end
    if (rst_ni && ack_i && e.irq) m_mask[e.lvl] = 1'b1;
    @(negedge clk_i);
    ack_i = 0; reti_i = 0;
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      @(ev_sample);
      while (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (irq_o !== e.irq || clr_o !== e.clr ||
            (e.irq && (src_o !== e.src || lvl_o !== e.lvl || vec_o !== e.vec))) begin
          n_fail++;
          $display("FAIL %s: irq=%b src=%0d lvl=%0d vec=%h clr=%b expected irq=%b src=%0d lvl=%0d vec=%h clr=%b",
                   e.tag, irq_o, src_o, lvl_o, vec_o, clr_o, e.irq, e.src, e.lvl, e.vec, e.clr);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    @(negedge clk_i);
    chk("R12 reset idle");
    rst_ni = 1;
    @(negedge clk_i);
    chk("R12 after reset no request");

    // R2 masking
    req_i = 7'h01; en_i = 8'h7F; chk("R2 master off");
    en_i = 8'hFE; chk("R2 own enable off");
    en_i = 8'hFF; req_i = 0;

    // R6 vector per source
    for (int i = 0; i < 7; i++) begin
      req_i = 7'(1 << i); chk($sformatf("R6 vector src %0d", i));
    end

    // R5 polling order within a level
    req_i = 7'h50; chk("R5 capture before serial");
    req_i = 7'h0C; chk("R5 ext1 before timer1");
    req_i = 7'h30; chk("R5 serial before timer2");
    req_i = 7'h70; chk("R5 capture before timer2");
    req_i = 7'h7F; chk("R5 all active");

    // R1 level wins over polling order
    req_i = 7'h21; prio_hi_i = 7'h20; prio_lo_i = 7'h20; chk("R1 level3 timer2 over ext0");
    prio_lo_i = 7'h01; chk("R1 level2 over level1");
    prio_hi_i = 7'h44; prio_lo_i = 7'h40; req_i = 7'h44; chk("R1 level3 capture over level2 ext1");
    prio_hi_i = 0; prio_lo_i = 0; req_i = 0;

    // nesting sequence
    prio_lo_i = 7'h03; req_i = 7'h02; chk("R7 timer0 level1 offered");
    ack_i = 1; chk("R8 timer0 clear on ack");
    chk("R7 R3 held request blocked after ack");
    req_i = 7'h03; chk("R3 same level ext0 blocked");
    prio_hi_i = 7'h04; req_i = 7'h07; chk("R4 level2 ext1 preempts");
    edge_i = 2'b00; ack_i = 1; chk("R9 level-triggered ext1 not cleared");
    chk("R3 nothing above level2");
    reti_i = 1; chk("R11 reti cycle");
    chk("R11 level2 retired ext1 offered again");
    req_i = 7'h03; chk("R11 level1 still in service");
    reti_i = 1; chk("R11 second reti cycle");
    chk("R4 lower request resumes");
    edge_i = 2'b01; ack_i = 1; chk("R9 edge ext0 cleared");
    reti_i = 1; req_i = 0; chk("R11 retire ext0");
    prio_hi_i = 0; prio_lo_i = 0;

    // R10 no hardware clear for serial, timer2, capture
    for (int i = 4; i < 7; i++) begin
      req_i = 7'(1 << i); ack_i = 1; chk($sformatf("R10 no clear src %0d", i));
      reti_i = 1; req_i = 0; chk("R10 retire");
    end

    // R8 timer1
    req_i = 7'h08; ack_i = 1; chk("R8 timer1 clear on ack");
    reti_i = 1; req_i = 0; chk("R8 retire");

    // R9 ext1 edge mode
    edge_i = 2'b10; req_i = 7'h04; ack_i = 1; chk("R9 edge ext1 cleared");
    reti_i = 1; req_i = 0; chk("R9 retire");

    done = 1;
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule